// File: doc/BRIEF.md
# Prescaled Edge Input Capture Channel

This block timestamps events on one external signal. The raw signal is first brought into the clock domain by a short synchroniser. It can then be inverted and is divided by a programmable ratio. The selected edges of the divided signal copy the value of an external free-running timer into a capture register and raise a one-cycle event pulse. A flag beside the captured value records which edge caused the capture.

Software sets up the channel through one 32-bit configuration word that is written with a strobe and can be read back at any time. Writing a 1 to the trigger bit of that word captures the timer at once, whatever the input is doing. The timer, interrupt handling and bus decoding are outside this block.

Top module: `edge_capture_chan`

## Requirements
- R1: While reset is asserted, and directly after it, the configuration reads as 0, the captured value is 0 and the event pulse is low.
- R2: Configuration bits 11:0 read back as last written. Bits 31:12 always read as 0, including the write-only trigger bit 12.
- R3: While the enable bit (bit 0) is clear, input edges never cause a capture.
- R4: Bit 2 enables capture on rising edges of the divided signal and bit 1 enables capture on falling edges. With both bits set, every divided edge captures.
- R5: With a divide field value N in bits 10:3, the divided signal rises on every (N+1)-th rising edge of the conditioned input and falls on the next falling edge of the conditioned input. With N = 0, every input edge passes through.
- R6: When bit 11 is set, the synchronised input is inverted before the divider. A high pulse on the pin then produces a divided rising edge at the pin's falling edge.
- R7: A write with bit 12 set captures the timer in that cycle, even when the channel is disabled, and reports polarity 0. If an input edge qualifies in the same cycle, only the forced capture takes place, as one event.
- R8: A pin change that is held long enough raises the event pulse at the third clock edge after the change. The captured value equals the timer value present at that edge. The polarity output is 1 for a rising divided edge and 0 for a falling one. Both outputs hold until the next capture.
- R9: Any configuration write and any cycle with the channel disabled clear the divider's progress, so counting restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe, one cycle per write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read-back |
| sig_in | input | 1 | Raw asynchronous input signal |
| timer_val | input | TIMER_W | Free-running timer value |
| cap_val | output | TIMER_W | Last captured timer value |
| cap_evt | output | 1 | One-cycle pulse per capture |
| cap_pol | output | 1 | 1 if the last capture came from a rising divided edge, else 0 |

## Verification
The assertions treat the timer and the raw pin as unconstrained. They rely only on reset being applied once before operation, and they relate the capture-fire decision to the registered outputs one cycle later. The bench changes the pin and the configuration at falling clock edges and holds every pin level for five cycles. As a result, each level passes the synchroniser cleanly and the number of captures in each scenario follows from the requirements. One scenario places a forced write in the exact cycle where a rising edge qualifies, to exercise the priority rule.

// File: rtl/capch_pkg.sv
`timescale 1ns/1ps
package capch_pkg;
  localparam int REG_W  = 32;
  localparam int PSC_W  = 8;
  localparam int CFG_W  = PSC_W + 4;   // enable, two edge bits, divider, invert
  localparam int SW_BIT = CFG_W;       // write-only trigger just above the stored bits

  typedef struct packed {
    logic             inv;
    logic [PSC_W-1:0] psc;
    logic             on_rise;
    logic             on_fall;
    logic             en;
  } cfg_t;

  function automatic cfg_t cfg_from_word(input logic [REG_W-1:0] w);
    return cfg_t'(w[CFG_W-1:0]);
  endfunction

  function automatic logic [REG_W-1:0] cfg_to_word(input cfg_t c);
    return {{(REG_W-CFG_W){1'b0}}, c};
  endfunction

  function automatic logic psc_terminal(input logic [PSC_W-1:0] cnt,
                                        input logic [PSC_W-1:0] lim);
    return cnt == lim;
  endfunction

  function automatic logic [PSC_W-1:0] psc_next(input logic [PSC_W-1:0] cnt,
                                                input logic [PSC_W-1:0] lim);
    return psc_terminal(cnt, lim) ? '0 : cnt + 1'b1;
  endfunction
endpackage

// File: rtl/capch_sync.sv
`timescale 1ns/1ps
module capch_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/capch_prescale.sv
`timescale 1ns/1ps
module capch_prescale
  import capch_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             lvl_rise,
  input  logic             lvl_fall,
  input  logic [PSC_W-1:0] lim,
  output logic             div_rise,
  output logic             div_fall
);
  logic [PSC_W-1:0] cnt;
  logic             gate;

  // divided signal rises on the terminal rising edge, falls with the input
  assign div_rise = lvl_rise & psc_terminal(cnt, lim);
  assign div_fall = lvl_fall & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      gate <= 1'b0;
    end else if (clr) begin
      cnt  <= '0;
      gate <= 1'b0;
    end else begin
      if (lvl_rise) begin
        cnt <= psc_next(cnt, lim);
        if (psc_terminal(cnt, lim)) gate <= 1'b1;
      end
      if (lvl_fall) gate <= 1'b0;
    end
  end
endmodule

// File: rtl/capch_latch.sv
`timescale 1ns/1ps
module capch_latch #(
  parameter int TW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sw_fire,
  input  logic          edge_fire,
  input  logic          edge_is_rise,
  input  logic [TW-1:0] timer,
  output logic [TW-1:0] cap_val,
  output logic          cap_evt,
  output logic          cap_pol
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_val <= '0;
      cap_evt <= 1'b0;
      cap_pol <= 1'b0;
    end else begin
      cap_evt <= sw_fire | edge_fire;
      if (sw_fire) begin
        cap_val <= timer;
        cap_pol <= 1'b0;
      end else if (edge_fire) begin
        cap_val <= timer;
        cap_pol <= edge_is_rise;
      end
    end
  end
endmodule

// File: rtl/edge_capture_chan.sv
`timescale 1ns/1ps
module edge_capture_chan
  import capch_pkg::*;
#(
  parameter int TIMER_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               sig_in,
  input  logic [TIMER_W-1:0] timer_val,
  output logic [TIMER_W-1:0] cap_val,
  output logic               cap_evt,
  output logic               cap_pol
);
  cfg_t cfg_q;
  logic sig_sync, cond, cond_q;
  logic lvl_rise, lvl_fall, psc_clr;
  logic div_rise, div_fall;
  logic edge_hit, sw_trig, cap_fire;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_from_word(cfg_wdata);

  assign cfg_rdata = cfg_to_word(cfg_q);

  capch_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(sig_in), .q(sig_sync)
  );

  assign cond = sig_sync ^ cfg_q.inv;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cond_q <= 1'b0;
    else        cond_q <= cond;

  assign lvl_rise = cond & ~cond_q;
  assign lvl_fall = ~cond & cond_q;
  assign psc_clr  = cfg_wr | ~cfg_q.en;

  capch_prescale u_psc (
    .clk(clk), .rst_n(rst_n), .clr(psc_clr),
    .lvl_rise(lvl_rise), .lvl_fall(lvl_fall), .lim(cfg_q.psc),
    .div_rise(div_rise), .div_fall(div_fall)
  );

  assign edge_hit = cfg_q.en & ((cfg_q.on_rise & div_rise) | (cfg_q.on_fall & div_fall));
  assign sw_trig  = cfg_wr & cfg_wdata[SW_BIT];
  assign cap_fire = sw_trig | edge_hit;

  capch_latch #(.TW(TIMER_W)) u_latch (
    .clk(clk), .rst_n(rst_n),
    .sw_fire(sw_trig), .edge_fire(edge_hit), .edge_is_rise(div_rise),
    .timer(timer_val),
    .cap_val(cap_val), .cap_evt(cap_evt), .cap_pol(cap_pol)
  );
endmodule

// File: rtl/edge_capture_chan_chk.sv
`timescale 1ns/1ps
module edge_capture_chan_chk #(
  parameter int TW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [31:0]   cfg_rdata,
  input logic [TW-1:0] timer_val,
  input logic [TW-1:0] cap_val,
  input logic          cap_evt,
  input logic          cap_pol,
  input logic          ch_en,
  input logic          sw_trig,
  input logic          cap_fire
);
  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[31:12] == 20'd0);

  // R3
  idle_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && !sw_trig) |=> !cap_evt);

  // R8
  capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_fire |=> (cap_evt && cap_val == $past(timer_val)));

  // R8
  hold_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_fire |=> (!cap_evt && $stable(cap_val) && $stable(cap_pol)));

  // R7
  forced_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_trig |=> (cap_evt && !cap_pol));

  // R4
  rise_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && cap_pol) |-> $past(cfg_rdata[2]));
endmodule

bind edge_capture_chan edge_capture_chan_chk #(.TW(TIMER_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rdata(cfg_rdata), .timer_val(timer_val),
  .cap_val(cap_val), .cap_evt(cap_evt), .cap_pol(cap_pol),
  .ch_en(cfg_q.en), .sw_trig(sw_trig), .cap_fire(cap_fire)
);

// File: tb/edge_capture_chan_tb.sv
`timescale 1ns/1ps
module edge_capture_chan_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic        sig_in = 1'b0;
  logic [31:0] timer_val = '0;
  logic [31:0] cfg_rdata, cap_val;
  logic        cap_evt, cap_pol;

  int checks = 0, errors = 0, evt_seen = 0;
  bit done = 0, cmp_on = 0, last_pol = 0;

  always #2 clk = ~clk;   // 250 MHz

  edge_capture_chan u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .sig_in(sig_in), .timer_val(timer_val),
    .cap_val(cap_val), .cap_evt(cap_evt), .cap_pol(cap_pol)
  );

  // behavioural reference model
  bit          hist[$];
  bit          m_prev, m_gate, m_evt, m_pol;
  int          m_cnt;
  logic [11:0] m_cfg;
  logic [31:0] m_val;

  always @(posedge clk) begin : model
    bit cond, rise, fall, pr, pf, en, sw, hit;
    int ratio;
    if (!rst_n) begin
      hist = {1'b0, 1'b0};
      m_prev = 0; m_gate = 0; m_evt = 0; m_pol = 0;
      m_cnt = 0; m_cfg = '0; m_val = '0;
    end else begin
      cond  = hist[0] ^ m_cfg[11];
      rise  = cond && !m_prev;
      fall  = !cond && m_prev;
      en    = m_cfg[0];
      ratio = int'(m_cfg[10:3]) + 1;
      pr    = en && rise && (m_cnt + 1 == ratio);
      pf    = en && fall && m_gate;
      sw    = cfg_wr && cfg_wdata[12];
      hit   = en && ((m_cfg[2] && pr) || (m_cfg[1] && pf));
      if (cfg_wr || !en) begin
        m_cnt = 0; m_gate = 0;
      end else begin
        if (rise) begin
          m_cnt++;
          if (m_cnt == ratio) begin m_cnt = 0; m_gate = 1; end
        end
        if (fall) m_gate = 0;
      end
      if (sw)       begin m_val = timer_val; m_evt = 1; m_pol = 0;  end
      else if (hit) begin m_val = timer_val; m_evt = 1; m_pol = pr; end
      else m_evt = 0;
      if (cfg_wr) m_cfg = cfg_wdata[11:0];
      m_prev = cond;
      void'(hist.pop_front());
      hist.push_back(sig_in);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    timer_val <= timer_val + 32'd3;
    if (cmp_on) begin
      chk(cfg_rdata === {20'd0, m_cfg}, "R2 readback", cfg_rdata, {20'd0, m_cfg});
      chk(cap_evt === m_evt, "R8 event pulse", {31'd0, cap_evt}, {31'd0, m_evt});
      chk(cap_pol === m_pol, "R8 polarity", {31'd0, cap_pol}, {31'd0, m_pol});
      chk(cap_val === m_val, "R8 captured value", cap_val, m_val);
      if (cap_evt) begin evt_seen++; last_pol = cap_pol; end
    end
  end

  task automatic write_cfg(input logic [31:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin
      sig_in = 1'b1; repeat (5) @(negedge clk);
      sig_in = 1'b0; repeat (5) @(negedge clk);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic count_is(input int base, input int exp, input string tag);
    chk(evt_seen - base == exp, tag, evt_seen - base, exp);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int base;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cfg_rdata === 32'd0, "R1 cfg in reset", cfg_rdata, 32'd0);
    chk(cap_val === 32'd0, "R1 cap_val in reset", cap_val, 32'd0);
    chk(cap_evt === 1'b0, "R1 cap_evt in reset", {31'd0, cap_evt}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    cmp_on = 1;
    chk(cfg_rdata === 32'd0, "R1 cfg after reset", cfg_rdata, 32'd0);

    // R2 reserved bits drop, stored bits return
    write_cfg(32'hFFFF_E5A4);
    @(negedge clk);
    chk(cfg_rdata === 32'h0000_05A4, "R2 masked readback", cfg_rdata, 32'h0000_05A4);

    // R3 disabled, both edges selected
    write_cfg(32'h6); settle(); base = evt_seen;
    pulses(6); settle();
    count_is(base, 0, "R3 disabled capture count");

    // R4 rising only, falling only, both
    write_cfg(32'h5); settle(); base = evt_seen;
    pulses(4); settle();
    count_is(base, 4, "R4 rising-only count");
    chk(last_pol == 1'b1, "R4 rising polarity", {31'd0, last_pol}, 32'd1);
    write_cfg(32'h3); settle(); base = evt_seen;
    pulses(4); settle();
    count_is(base, 4, "R4 falling-only count");
    chk(last_pol == 1'b0, "R4 falling polarity", {31'd0, last_pol}, 32'd0);
    write_cfg(32'h7); settle(); base = evt_seen;
    pulses(4); settle();
    count_is(base, 8, "R4 both-edges count");

    // R5 divide by 3
    write_cfg(32'h15); settle(); base = evt_seen;
    pulses(9); settle();
    count_is(base, 3, "R5 divide-by-3 rising count");
    write_cfg(32'h17); settle(); base = evt_seen;
    pulses(9); settle();
    count_is(base, 6, "R5 divide-by-3 both count");

    // R6 inversion: arm while disabled, then enable
    write_cfg(32'h804); settle();
    write_cfg(32'h805); settle(); base = evt_seen;
    pulses(4); settle();
    count_is(base, 4, "R6 inverted rising count");
    chk(last_pol == 1'b1, "R6 inverted polarity", {31'd0, last_pol}, 32'd1);
    write_cfg(32'h004); settle();

    // R9 rewrite clears progress (divide by 4)
    write_cfg(32'h1D); settle(); base = evt_seen;
    pulses(2); write_cfg(32'h1D); pulses(3); settle();
    count_is(base, 0, "R9 rewrite restarts divider");
    pulses(1); settle();
    count_is(base, 1, "R9 divider completes after restart");
    write_cfg(32'h1D); settle(); base = evt_seen;
    pulses(2); write_cfg(32'h1C); settle(); write_cfg(32'h1D); pulses(3); settle();
    count_is(base, 0, "R9 disable restarts divider");

    // R7 forced capture while disabled
    write_cfg(32'h0); settle(); base = evt_seen;
    write_cfg(32'h1000); settle();
    count_is(base, 1, "R7 forced capture while disabled");
    chk(last_pol == 1'b0, "R7 forced polarity", {31'd0, last_pol}, 32'd0);
    chk(cfg_rdata === 32'd0, "R7 trigger reads zero", cfg_rdata, 32'd0);

    // R7 forced write coinciding with a qualified rising edge
    write_cfg(32'h5); settle(); base = evt_seen;
    sig_in = 1'b1;
    @(negedge clk); @(negedge clk);
    write_cfg(32'h1005);
    repeat (4) @(negedge clk);
    sig_in = 1'b0; settle();
    count_is(base, 1, "R7 coincident single event");
    chk(last_pol == 1'b0, "R7 coincident polarity", {31'd0, last_pol}, 32'd0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule